// File: doc/BRIEF.md
# Bark-and-Bite Watchdog Timer

This block is a memory-mapped watchdog for safety-critical systems. Software arms it with a 24-bit timeout and must keep writing a fixed key to a feed register. The timeout counter steps once every 4096 clock cycles. When it reaches half of the programmed timeout, the block raises a one-cycle interrupt request, the early warning or "bark". When it reaches the full timeout, it issues a one-cycle system reset request, the "bite".

The control register has these further features:
- A lock bit that freezes the configuration. Only the external power-on reset clears it.
- A strict mode that turns illegal accesses into an immediate reset request. The illegal accesses are a feed with the wrong key and a control write while locked.
- Two permission bits that let the counter keep running while the CPU is halted for debug or is sleeping.
- A read-only field that records why the last reset happened.

Two events count as soft resets here: the watchdog's own reset request and a debugger-issued system reset. A soft reset clears only the counting state. The configuration, the lock and the recorded cause survive it, so software can read after the restart why the restart happened.

Top module: `barkbite_watchdog`

## Requirements
- R1: After the external reset `rst`, the control word reads 0 and `irq_o` and `rst_req_o` are low.
  - The control register is at byte offset 0x0. Its layout is:
    - bit 0: enable
    - bit 1: lock
    - bit 2: run-in-debug
    - bit 3: run-in-sleep
    - bit 4: strict
    - bits 6:5: reset cause
    - bit 7: reads 0
    - bits 31:8: timeout
  - The feed register is at byte offset 0x4 and reads 0.
  - Read data appears on `bus_rdata` in the cycle after the read strobe.
- R2: While enabled and not paused, the counter advances once per 4096 cycles. `irq_o` pulses for one cycle when the counter reaches timeout>>1. Counting from the enabling write, that is 4096·(timeout>>1) cycles after the write.
- R3: While the enable bit is 0, the counter and the prescaler are held at zero, and neither `irq_o` nor `rst_req_o` can assert.
- R4: `rst_req_o` pulses for one cycle when the counter reaches a nonzero timeout. The counter then restarts from zero. A timeout of 0 never requests a reset.
- R5: `irq_o` fires at most once per pass of the counter from zero.
- R6: Writing 0x709D1AB3 to the feed register clears the counter and the prescaler, even while the configuration is locked. Without strict mode, any other value written there has no effect.
- R7: The lock bit is set only if enable is already 1 or is set in the same write. A set lock ignores every later control write, keeps reads working, and clears only on `rst`.
- R8: With strict and enable set, two accesses raise `rst_req_o` in the cycle after the write: a feed write with a wrong key, and any control write while locked. The counter is cleared as well.
- R9: By default, the counter pauses while `dbg_mode_i` is high and while `sleep_i` is high. The run-in-debug and run-in-sleep bits keep it counting in the matching mode.
- R10: The reset-cause field reads 0 after `rst`, 1 after an `ocd_rst_i` pulse, and 2 after any `rst_req_o`. The watchdog request wins if both occur in the same cycle. The configuration and the cause survive the soft resets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high external power-on reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dbg_mode_i | input | 1 | CPU is halted in debug mode |
| sleep_i | input | 1 | CPU is sleeping |
| ocd_rst_i | input | 1 | One-cycle pulse: debugger issued a system reset |
| irq_o | output | 1 | One-cycle half-timeout interrupt request |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench measures the bark and the bite to the exact cycle after the enabling write. An off-by-one in the prescaler or the compare would move the pulse by 4096 cycles or fire it twice.

It feeds twice, once with the key and once with a wrong value. It also disables the block mid-count and then re-enables it. A design that left the counter uncleared would bark early after the feed or the re-enable. A design that cleared on any feed value would never bite.

It sets the lock without enable and writes to a locked register, with and without strict mode. A leaky lock shows up as a changed read-back. A missing strict check shows up as an absent reset request.

It holds the debug and sleep inputs high to confirm the pause, and reads the cause after every kind of reset, including the debugger pulse.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam logic [31:0] FEED_KEY = 32'h709D1AB3;
  localparam logic [3:0]  OFS_CTRL = 4'h0;
  localparam logic [3:0]  OFS_FEED = 4'h4;

  typedef enum logic [1:0] {
    CAUSE_EXT = 2'd0,
    CAUSE_DBG = 2'd1,
    CAUSE_WDG = 2'd2
  } cause_e;

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int PRESC_W = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  output logic tick
);

  logic [PRESC_W-1:0] div_q;

  // The divider wraps to zero by itself on the terminal count.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q <= '0;
    end else if (run) begin
      div_q <= div_q + 1'b1;
    end
  end

  assign tick = run && (&div_q);

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] timeout,
  output logic [CNT_W-1:0] cnt,
  output logic             half_hit,
  output logic             full_hit
);

  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] half_lvl;

  assign cnt_nxt  = cnt + 1'b1;
  assign half_lvl = timeout >> 1;

  // Both events fire on the step that lands on the level.
  assign half_hit = tick && (cnt_nxt == half_lvl);
  assign full_hit = tick && (timeout != '0) && (cnt_nxt == timeout);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (full_hit) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt_nxt;
    end
  end

endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bite_i,
  input  logic              ocd_rst_i,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              en,
  output logic              lock,
  output logic              run_dbg,
  output logic              run_sleep,
  output logic              strict,
  output logic [CNT_W-1:0]  timeout,
  output cause_e            cause,
  output logic              feed_ok,
  output logic              strict_viol
);

  localparam int TMO_LSB = DATA_W - CNT_W;

  logic ctrl_sel;
  logic feed_sel;
  logic ctrl_wr;
  logic feed_wr;
  logic [DATA_W-1:0] ctrl_word;
  logic unused_wbits;

  assign ctrl_sel = (bus_addr == ADDR_W'(OFS_CTRL));
  assign feed_sel = (bus_addr == ADDR_W'(OFS_FEED));
  assign ctrl_wr  = bus_we && ctrl_sel;
  assign feed_wr  = bus_we && feed_sel;

  assign feed_ok     = feed_wr && (bus_wdata == DATA_W'(FEED_KEY));
  assign strict_viol = en && strict && ((feed_wr && !feed_ok) || (ctrl_wr && lock));

  assign unused_wbits = ^bus_wdata[TMO_LSB-1:5];

  // Configuration: cleared only by the power-on reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      en        <= 1'b0;
      lock      <= 1'b0;
      run_dbg   <= 1'b0;
      run_sleep <= 1'b0;
      strict    <= 1'b0;
      timeout   <= '0;
    end else if (ctrl_wr && !lock) begin
      en        <= bus_wdata[0];
      lock      <= bus_wdata[1] && (en || bus_wdata[0]);
      run_dbg   <= bus_wdata[2];
      run_sleep <= bus_wdata[3];
      strict    <= bus_wdata[4];
      timeout   <= bus_wdata[DATA_W-1:TMO_LSB];
    end
  end

  // Reset cause: the watchdog request has priority over the debugger.
  always_ff @(posedge clk) begin
    if (rst) begin
      cause <= CAUSE_EXT;
    end else if (bite_i || strict_viol) begin
      cause <= CAUSE_WDG;
    end else if (ocd_rst_i) begin
      cause <= CAUSE_DBG;
    end
  end

  assign ctrl_word = {timeout, {(TMO_LSB-7){1'b0}}, cause, strict, run_sleep, run_dbg, lock, en};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= (bus_re && ctrl_sel) ? ctrl_word : '0;
    end
  end

endmodule

// File: rtl/barkbite_watchdog.sv
module barkbite_watchdog
  import wdg_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int PRESC_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dbg_mode_i,
  input  logic              sleep_i,
  input  logic              ocd_rst_i,
  output logic              irq_o,
  output logic              rst_req_o
);

  localparam int CNT_W = DATA_W - 8;

  logic             ctrl_en;
  logic             ctrl_lock;
  logic             run_dbg;
  logic             run_sleep;
  logic             strict;
  logic [CNT_W-1:0] timeout;
  cause_e           cause;
  logic             feed_ok;
  logic             strict_viol;
  logic             active;
  logic             clr;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             half_hit;
  logic             full_hit;
  logic             fire_bite;

  assign active    = ctrl_en && (run_dbg || !dbg_mode_i) && (run_sleep || !sleep_i);
  assign clr       = !ctrl_en || feed_ok || strict_viol || ocd_rst_i;
  assign fire_bite = full_hit && !clr;

  wdg_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .bus_we      (bus_we),
    .bus_re      (bus_re),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bite_i      (fire_bite),
    .ocd_rst_i   (ocd_rst_i),
    .bus_rdata   (bus_rdata),
    .en          (ctrl_en),
    .lock        (ctrl_lock),
    .run_dbg     (run_dbg),
    .run_sleep   (run_sleep),
    .strict      (strict),
    .timeout     (timeout),
    .cause       (cause),
    .feed_ok     (feed_ok),
    .strict_viol (strict_viol)
  );

  wdg_prescaler #(
    .PRESC_W (PRESC_W)
  ) u_presc (
    .clk  (clk),
    .rst  (rst),
    .run  (active),
    .clr  (clr),
    .tick (tick)
  );

  wdg_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .tick     (tick),
    .timeout  (timeout),
    .cnt      (cnt),
    .half_hit (half_hit),
    .full_hit (full_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      irq_o     <= half_hit && !clr;
      rst_req_o <= fire_bite || strict_viol;
    end
  end

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic             en,
  input logic             lock,
  input logic [1:0]       cause,
  input logic [CNT_W-1:0] cnt,
  input logic             feed_ok
);

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o); // R5

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (!irq_o && !rst_req_o)); // R3

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(lock) |-> lock); // R7

  AST_LOCK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    lock |-> en); // R7

  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> (cause == 2'd2)); // R10

  AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    cause != 2'd3); // R10

  AST_FEED_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(feed_ok) |-> (cnt == '0)); // R6

endmodule

bind barkbite_watchdog wdg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o),
  .en        (ctrl_en),
  .lock      (ctrl_lock),
  .cause     (cause),
  .cnt       (cnt),
  .feed_ok   (feed_ok)
);

// File: tb/barkbite_watchdog_test.sv
`timescale 1ns/1ps
module barkbite_watchdog_test;

  localparam logic [3:0]  A_CTRL = 4'h0;
  localparam logic [3:0]  A_FEED = 4'h4;
  localparam logic [31:0] KEY    = 32'h709D1AB3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        dbg_mode_i = 1'b0;
  logic        sleep_i = 1'b0;
  logic        ocd_rst_i = 1'b0;
  logic        irq_o;
  logic        rst_req_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  barkbite_watchdog uut (
    .clk        (clk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .dbg_mode_i (dbg_mode_i),
    .sleep_i    (sleep_i),
    .ocd_rst_i  (ocd_rst_i),
    .irq_o      (irq_o),
    .rst_req_o  (rst_req_o)
  );

  function automatic logic [31:0] mk(input int tmo, input bit st, input bit rs,
                                     input bit rd, input bit lk, input bit en,
                                     input int cs);
    logic [31:0] t;
    logic [31:0] c;
    t = tmo;
    c = cs;
    return {t[23:0], 1'b0, c[1:0], st, rs, rd, lk, en};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    @(posedge clk);
    #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_re = 1'b1;
    bus_addr = a;
    @(posedge clk);
    #1;
    d = bus_rdata;
    bus_re = 1'b0;
  endtask

  // Counts pulses over n cycles; first index is 1-based from the last edge.
  task automatic watch(input int n, output int irq_n, output int irq_first,
                       output int rq_n, output int rq_first);
    irq_n = 0; irq_first = 0; rq_n = 0; rq_first = 0;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk);
      #1;
      if (irq_o) begin
        irq_n++;
        if (irq_first == 0) irq_first = i;
      end
      if (rst_req_o) begin
        rq_n++;
        if (rq_first == 0) rq_first = i;
      end
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(A_CTRL, d);
    check("R1 ctrl after reset", d, 32'h0);
    rd(A_FEED, d);
    check("R1 feed reads zero", d, 32'h0);
    check("R1 irq low", {31'b0, irq_o}, 32'h0);
    check("R1 rst_req low", {31'b0, rst_req_o}, 32'h0);
  endtask

  task automatic t_bark_bite();
    int in, ifst, rn, rf;
    logic [31:0] d;
    do_reset();
    wr(A_CTRL, mk(4, 0, 0, 0, 0, 1, 0));
    watch(16400, in, ifst, rn, rf);
    check("R2 bark cycle", ifst, 8192);
    check("R5 bark once", in, 1);
    check("R4 bite cycle", rf, 16384);
    check("R4 bite single pulse", rn, 1);
    rd(A_CTRL, d);
    check("R10 cause after bite, config kept", d, mk(4, 0, 0, 0, 0, 1, 2));
  endtask

  task automatic t_disable();
    int in, ifst, rn, rf;
    do_reset();
    wr(A_CTRL, mk(4, 0, 0, 0, 0, 1, 0));
    watch(5000, in, ifst, rn, rf);
    wr(A_CTRL, mk(4, 0, 0, 0, 0, 0, 0));
    watch(17000, in, ifst, rn, rf);
    check("R3 no irq while disabled", in, 0);
    check("R3 no reset while disabled", rn, 0);
    wr(A_CTRL, mk(4, 0, 0, 0, 0, 1, 0));
    watch(8200, in, ifst, rn, rf);
    check("R3 counter cleared by disable", ifst, 8192);
  endtask

  task automatic t_feed();
    int in, ifst, rn, rf;
    do_reset();
    wr(A_CTRL, mk(4, 0, 0, 0, 0, 1, 0));
    watch(12000, in, ifst, rn, rf);
    check("R2 bark before feed", ifst, 8192);
    wr(A_FEED, KEY);
    watch(9000, in, ifst, rn, rf);
    check("R6 feed restarts count", ifst, 8192);
    check("R4 no bite after feed", rn, 0);
    wr(A_FEED, 32'h12345678);
    check("R6 wrong key no request", {31'b0, rst_req_o}, 32'h0);
    watch(8000, in, ifst, rn, rf);
    check("R6 wrong key does not clear", rf, 7383);
  endtask

  task automatic t_lock();
    int in, ifst, rn, rf;
    logic [31:0] d;
    do_reset();
    wr(A_CTRL, mk(2, 0, 0, 0, 1, 0, 0));
    rd(A_CTRL, d);
    check("R7 lock refused without enable", d, mk(2, 0, 0, 0, 0, 0, 0));
    wr(A_CTRL, mk(2, 0, 0, 0, 1, 1, 0));
    rd(A_CTRL, d);
    check("R7 lock with enable, readable", d, mk(2, 0, 0, 0, 1, 1, 0));
    wr(A_CTRL, 32'h0);
    check("R8 locked write without strict no request", {31'b0, rst_req_o}, 32'h0);
    rd(A_CTRL, d);
    check("R7 locked write ignored", d, mk(2, 0, 0, 0, 1, 1, 0));
    wr(A_FEED, KEY);
    watch(8200, in, ifst, rn, rf);
    check("R6 feed while locked", rf, 8192);
    check("R7 still enabled, barks", ifst, 4096);
    do_reset();
    rd(A_CTRL, d);
    check("R10 external reset clears lock and cause", d, 32'h0);
  endtask

  task automatic t_strict();
    logic [31:0] d;
    do_reset();
    wr(A_CTRL, mk(100, 1, 0, 0, 0, 1, 0));
    wr(A_FEED, 32'hDEADBEEF);
    check("R8 wrong key forces request", {31'b0, rst_req_o}, 32'h1);
    @(posedge clk);
    #1;
    check("R8 request is one cycle", {31'b0, rst_req_o}, 32'h0);
    rd(A_CTRL, d);
    check("R10 cause after strict", d, mk(100, 1, 0, 0, 0, 1, 2));
    wr(A_CTRL, mk(100, 1, 0, 0, 1, 1, 0));
    wr(A_CTRL, 32'h0);
    check("R8 locked write forces request", {31'b0, rst_req_o}, 32'h1);
    rd(A_CTRL, d);
    check("R7 strict locked config kept", d, mk(100, 1, 0, 0, 1, 1, 2));
  endtask

  task automatic t_pause();
    int in, ifst, rn, rf;
    do_reset();
    dbg_mode_i = 1'b1;
    wr(A_CTRL, mk(4, 0, 0, 0, 0, 1, 0));
    watch(17000, in, ifst, rn, rf);
    check("R9 debug pauses irq", in, 0);
    check("R9 debug pauses bite", rn, 0);
    wr(A_CTRL, mk(4, 0, 0, 1, 0, 1, 0));
    watch(8200, in, ifst, rn, rf);
    check("R9 run-in-debug counts", ifst, 8192);
    dbg_mode_i = 1'b0;
    do_reset();
    sleep_i = 1'b1;
    wr(A_CTRL, mk(4, 0, 0, 0, 0, 1, 0));
    watch(9000, in, ifst, rn, rf);
    check("R9 sleep pauses", in, 0);
    wr(A_CTRL, mk(4, 0, 1, 0, 0, 1, 0));
    watch(8200, in, ifst, rn, rf);
    check("R9 run-in-sleep counts", ifst, 8192);
    sleep_i = 1'b0;
  endtask

  task automatic t_ocd();
    logic [31:0] d;
    do_reset();
    @(negedge clk);
    ocd_rst_i = 1'b1;
    @(posedge clk);
    #1;
    ocd_rst_i = 1'b0;
    check("R10 debugger reset raises no request", {31'b0, rst_req_o}, 32'h0);
    rd(A_CTRL, d);
    check("R10 cause after debugger reset", d, mk(0, 0, 0, 0, 0, 0, 1));
  endtask

  task automatic t_zero();
    int in, ifst, rn, rf;
    do_reset();
    wr(A_CTRL, mk(0, 0, 0, 0, 0, 1, 0));
    watch(9000, in, ifst, rn, rf);
    check("R4 zero timeout never bites", rn, 0);
    check("R2 zero timeout never barks", in, 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL all: watchdog expired, actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_bark_bite();
    t_disable();
    t_feed();
    t_lock();
    t_strict();
    t_pause();
    t_ocd();
    t_zero();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule